// File: doc/BRIEF.md
# Paged address translation unit

This block maps a 16-bit virtual address to a 24-bit physical address through a page table held on chip. The table has 64 process slots. Each slot holds 64 entries, and each entry describes one 1 KB page. A 6-bit slot register picks the active slot. A single-cycle write strobe fills one table entry from a 16-bit data word.

Translation is combinational from the address and request inputs, so a request and its physical address, qualified request and fault flags all appear in the same cycle. Each entry holds a present bit and a writable bit above a 14-bit physical page number. An access to a page that is absent raises a page fault. A write to a read-only page raises a protection fault. Either fault withholds the memory request. While paging is off, addresses pass through zero-extended and no fault is raised.

Top module: `pageXlat`

## Requirements
- R1: The slot register resets to 0. It takes `slotIn` at a rising clock edge where `slotLoad` is high, and it otherwise holds its value.
- R2: While `pagingEn` is low, `physAddr` equals `{8'h00, virtAddr}`, `memReq` equals `reqValid`, and both fault outputs are low.
- R3: While `pagingEn` is high, the table index is `{virtAddr[15:10], slot}`, with the virtual page in the upper six bits. `physAddr` is `{entry[13:0], virtAddr[9:0]}`.
- R4: While `pagingEn` and `reqValid` are high and the indexed entry has bit 15 (present) clear, `pageFault` is high and `memReq` is low.
- R5: While `pagingEn`, `reqValid` and `reqWrite` are high and the indexed entry has bit 15 set and bit 14 (writable) clear, `protFault` is high and `memReq` is low. A read from such a page is allowed. The two faults are never high together.
- R6: A cycle with `entryWrite` high stores `entryData` at index `{virtAddr[15:10], slot}`. Accesses see the new entry from the next cycle on. An access in the same cycle as the write sees the old entry.
- R7: When `slotLoad` and `entryWrite` are high in the same cycle, the entry is written into the slot that was active before the load.
- R8: `memWrite` equals `memReq & reqWrite`. With `reqValid` low, `memReq`, `memWrite` and both faults are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| virtAddr | input | 16 | Virtual address, also the write index source |
| reqValid | input | 1 | Memory access request |
| reqWrite | input | 1 | Request is a write |
| slotLoad | input | 1 | Load the slot register |
| slotIn | input | 6 | New slot number |
| entryWrite | input | 1 | Store `entryData` into the table |
| entryData | input | 16 | Table entry: present, writable, page number |
| pagingEn | input | 1 | Enable translation |
| physAddr | output | 24 | Physical address |
| memReq | output | 1 | Qualified memory request |
| memWrite | output | 1 | Qualified write |
| pageFault | output | 1 | Access to an absent page |
| protFault | output | 1 | Write to a read-only page |

## Verification
Two pairs of functions can fall in the same cycle. A slot load can coincide with a table write, and a table write can coincide with an access that reads the same entry. The bench drives both pairs directly. Directed cycles fill an entry in the old slot, and random cycles also mix writes into live slots. A shadow table in the bench judges each pair: it commits writes with the slot that was active before the edge, and it answers same-cycle accesses from the contents before the write.

// File: rtl/xlatPkg.sv
package xlatPkg;
  typedef struct packed {
    logic tableWe;
    logic slotWe;
  } xlatStrobes_t;
endpackage

// File: rtl/xlatDatapath.sv
module xlatDatapath
  import xlatPkg::*;
#(
  parameter int VA_W    = 16,
  parameter int PA_W    = 24,
  parameter int OFF_W   = 10,
  parameter int SLOT_W  = 6,
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlatStrobes_t       strb,
  input  logic [VA_W-1:0]    virtAddr,
  input  logic [SLOT_W-1:0]  slotIn,
  input  logic [ENTRY_W-1:0] entryData,
  input  logic               pagingEn,
  output logic               entPresent,
  output logic               entWritable,
  output logic [PA_W-1:0]    physAddr
);
  localparam int PAGE_W  = VA_W - OFF_W;
  localparam int IDX_W   = PAGE_W + SLOT_W;
  localparam int DEPTH   = 1 << IDX_W;
  localparam int PPN_W   = PA_W - OFF_W;
  localparam int PRES_B  = ENTRY_W - 1;
  localparam int WR_B    = ENTRY_W - 2;

  logic [SLOT_W-1:0]  slotReg;
  logic [ENTRY_W-1:0] pageTable [DEPTH];
  logic [IDX_W-1:0]   tblIdx;
  logic [ENTRY_W-1:0] curEntry;
  logic [PA_W-1:0]    flatAddr;
  logic [PA_W-1:0]    mappedAddr;

  // Virtual page in the upper index bits, slot in the lower ones.
  assign tblIdx   = {virtAddr[VA_W-1:OFF_W], slotReg};
  assign curEntry = pageTable[tblIdx];

  always_ff @(posedge clk) begin
    if (!rstN) slotReg <= '0;
    else if (strb.slotWe) slotReg <= slotIn;
  end

  always_ff @(posedge clk) begin
    if (strb.tableWe) pageTable[tblIdx] <= entryData;
  end

  generate
    if (PA_W > VA_W) begin : g_widen
      assign flatAddr = {{(PA_W-VA_W){1'b0}}, virtAddr};
    end else begin : g_trunc
      assign flatAddr = virtAddr[PA_W-1:0];
    end
  endgenerate

  assign mappedAddr  = {curEntry[PPN_W-1:0], virtAddr[OFF_W-1:0]};
  assign physAddr    = pagingEn ? mappedAddr : flatAddr;
  assign entPresent  = curEntry[PRES_B];
  assign entWritable = curEntry[WR_B];

  a_r1_slot_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.slotWe |=> slotReg == $past(slotIn));
  a_r1_slot_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.slotWe |=> $stable(slotReg));
  a_r6_entry_stored: assert property (@(posedge clk) disable iff (!rstN)
    strb.tableWe |=> pageTable[$past(tblIdx)] == $past(entryData));
endmodule

// File: rtl/xlatControl.sv
module xlatControl
  import xlatPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         slotLoad,
  input  logic         entryWrite,
  input  logic         pagingEn,
  input  logic         entPresent,
  input  logic         entWritable,
  output xlatStrobes_t strb,
  output logic         memReq,
  output logic         memWrite,
  output logic         pageFault,
  output logic         protFault
);
  logic absentHit;
  logic roHit;

  always_comb begin
    strb.tableWe = entryWrite;
    strb.slotWe  = slotLoad;
  end

  assign absentHit = pagingEn & reqValid & ~entPresent;
  assign roHit     = pagingEn & reqValid & reqWrite & entPresent & ~entWritable;
  assign pageFault = absentHit;
  assign protFault = roHit;
  assign memReq    = reqValid & ~absentHit & ~roHit;
  assign memWrite  = memReq & reqWrite;

  a_r2_bypass_clean: assert property (@(posedge clk) disable iff (!rstN)
    !pagingEn |-> (!pageFault && !protFault && memReq == reqValid));
  a_r4_absent_blocks: assert property (@(posedge clk) disable iff (!rstN)
    pageFault |-> !memReq);
  a_r5_readonly_blocks: assert property (@(posedge clk) disable iff (!rstN)
    protFault |-> (!memReq && reqWrite));
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pageFault && protFault));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!memReq && !memWrite && !pageFault && !protFault));
endmodule

// File: rtl/pageXlat.sv
module pageXlat
  import xlatPkg::*;
#(
  parameter int VA_W    = 16,
  parameter int PA_W    = 24,
  parameter int OFF_W   = 10,
  parameter int SLOT_W  = 6,
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [VA_W-1:0]    virtAddr,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic               slotLoad,
  input  logic [SLOT_W-1:0]  slotIn,
  input  logic               entryWrite,
  input  logic [ENTRY_W-1:0] entryData,
  input  logic               pagingEn,
  output logic [PA_W-1:0]    physAddr,
  output logic               memReq,
  output logic               memWrite,
  output logic               pageFault,
  output logic               protFault
);
  xlatStrobes_t strb;
  logic entPresent;
  logic entWritable;

  xlatControl i_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .slotLoad(slotLoad), .entryWrite(entryWrite), .pagingEn(pagingEn),
    .entPresent(entPresent), .entWritable(entWritable), .strb(strb),
    .memReq(memReq), .memWrite(memWrite), .pageFault(pageFault),
    .protFault(protFault)
  );

  xlatDatapath #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .SLOT_W(SLOT_W), .ENTRY_W(ENTRY_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .virtAddr(virtAddr), .slotIn(slotIn),
    .entryData(entryData), .pagingEn(pagingEn), .entPresent(entPresent),
    .entWritable(entWritable), .physAddr(physAddr)
  );
endmodule

// File: tb/test_pageXlat.sv
module test_pageXlat;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] virtAddr = '0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, slotLoad = 1'b0;
  logic [5:0]  slotIn = '0;
  logic        entryWrite = 1'b0;
  logic [15:0] entryData = '0;
  logic        pagingEn = 1'b0;
  logic [23:0] physAddr;
  logic        memReq, memWrite, pageFault, protFault;

  int checks = 0;
  int fails = 0;
  logic [15:0] model [4096];
  logic [5:0]  modelSlot = '0;
  logic [5:0]  liveSlots [3] = '{6'd0, 6'd5, 6'd63};

  always #5 clk = ~clk;

  pageXlat i_pageXlat (
    .clk(clk), .rstN(rstN), .virtAddr(virtAddr), .reqValid(reqValid),
    .reqWrite(reqWrite), .slotLoad(slotLoad), .slotIn(slotIn),
    .entryWrite(entryWrite), .entryData(entryData), .pagingEn(pagingEn),
    .physAddr(physAddr), .memReq(memReq), .memWrite(memWrite),
    .pageFault(pageFault), .protFault(protFault)
  );

  function automatic logic [27:0] expect_out(input logic [15:0] va, input logic rv,
                                             input logic rw, input logic pe);
    logic [15:0] e;
    logic pf, prf, mr;
    logic [23:0] pa;
    if (!pe) begin
      pa = {8'h00, va}; pf = 1'b0; prf = 1'b0; mr = rv;
    end else begin
      e   = model[{va[15:10], modelSlot}];
      pa  = {e[13:0], va[9:0]};
      pf  = rv & ~e[15];
      prf = rv & rw & e[15] & ~e[14];
      mr  = rv & ~pf & ~prf;
    end
    return {pa, mr, mr & rw, pf, prf};
  endfunction

  task automatic cyc(input string tag, input logic [15:0] va, input logic rv,
                     input logic rw, input logic sl, input logic [5:0] si,
                     input logic ew, input logic [15:0] ed, input logic pe);
    logic [27:0] exp, act;
    @(negedge clk);
    virtAddr = va; reqValid = rv; reqWrite = rw; slotLoad = sl; slotIn = si;
    entryWrite = ew; entryData = ed; pagingEn = pe;
    #2;
    exp = expect_out(va, rv, rw, pe);
    act = {physAddr, memReq, memWrite, pageFault, protFault};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s va=%h act=%h exp=%h", tag, va, act, exp);
    end
    @(posedge clk);
    #1;
    if (ew) model[{va[15:10], modelSlot}] = ed;
    if (sl) modelSlot = si;
  endtask

  initial begin : watchdog
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if ({memReq, memWrite, pageFault, protFault, physAddr} !== 28'h0) begin
      fails++;
      $display("FAIL R8 reset outputs act=%h exp=0",
               {memReq, memWrite, pageFault, protFault, physAddr});
    end
    rstN = 1'b1;
    // Fill three slots; each write cycle also checks pass-through (R2, R6).
    foreach (liveSlots[s]) begin
      cyc("R1 slot select", 16'h0, 1'b0, 1'b0, 1'b1, liveSlots[s], 1'b0, 16'h0, 1'b0);
      for (int p = 0; p < 64; p++)
        cyc("R2 R6 fill", {p[5:0], 10'($urandom)}, 1'($urandom), 1'($urandom),
            1'b0, 6'h0, 1'b1, 16'($urandom), 1'b0);
    end
    // Directed R3/R4/R5 on slot 63 (active now).
    cyc("R6 set present rw", 16'h0400, 1'b0, 1'b0, 1'b0, 6'h0, 1'b1, 16'hC123, 1'b1);
    cyc("R3 translate", 16'h07FF, 1'b1, 1'b1, 1'b0, 6'h0, 1'b0, 16'h0, 1'b1);
    cyc("R6 set absent", 16'h0800, 1'b0, 1'b0, 1'b0, 6'h0, 1'b1, 16'h3FFF, 1'b1);
    cyc("R4 absent read", 16'h0801, 1'b1, 1'b0, 1'b0, 6'h0, 1'b0, 16'h0, 1'b1);
    cyc("R2 absent bypass", 16'h0801, 1'b1, 1'b1, 1'b0, 6'h0, 1'b0, 16'h0, 1'b0);
    cyc("R6 set readonly", 16'h0C00, 1'b0, 1'b0, 1'b0, 6'h0, 1'b1, 16'h8055, 1'b1);
    cyc("R5 readonly write", 16'h0C10, 1'b1, 1'b1, 1'b0, 6'h0, 1'b0, 16'h0, 1'b1);
    cyc("R5 readonly read", 16'h0C10, 1'b1, 1'b0, 1'b0, 6'h0, 1'b0, 16'h0, 1'b1);
    cyc("R8 idle", 16'h0C10, 1'b0, 1'b1, 1'b0, 6'h0, 1'b0, 16'h0, 1'b1);
    // R6: access in same cycle as a rewrite sees the old entry, next cycle the new one.
    cyc("R6 same-cycle old", 16'h0C20, 1'b1, 1'b1, 1'b0, 6'h0, 1'b1, 16'hC777, 1'b1);
    cyc("R6 next-cycle new", 16'h0C20, 1'b1, 1'b1, 1'b0, 6'h0, 1'b0, 16'h0, 1'b1);
    // R7: slot load with a write; the write lands in slot 63, not slot 5.
    cyc("R7 load+write", 16'h1000, 1'b0, 1'b0, 1'b1, 6'd5, 1'b1, 16'hC3AA, 1'b1);
    cyc("R7 slot5 untouched", 16'h1001, 1'b1, 1'b0, 1'b0, 6'h0, 1'b0, 16'h0, 1'b1);
    cyc("R1 back to 63", 16'h1001, 1'b0, 1'b0, 1'b1, 6'd63, 1'b0, 16'h0, 1'b1);
    cyc("R7 slot63 written", 16'h1002, 1'b1, 1'b0, 1'b0, 6'h0, 1'b0, 16'h0, 1'b1);
    // Constrained random mix over the filled slots.
    for (int i = 0; i < 3000; i++) begin
      logic doLoad;
      doLoad = ($urandom % 8) == 0;
      cyc("R3 R4 R5 R8 random", 16'($urandom), 1'($urandom), 1'($urandom), doLoad,
          liveSlots[$urandom % 3], ($urandom % 6) == 0, 16'($urandom),
          ($urandom % 5) != 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule